// File: doc/BRIEF.md
# On-chip data RAM overlay controller

This block sits between an 8-bit CPU core and its external data space. The core reaches that space through a 16-bit pointer, and every access takes two cycles. The block decides whether each access is served by a 256-byte on-chip RAM or sent out as a request on the external memory bus. The on-chip RAM can only replace the top 256 bytes of the 64 KB space, from FF00h to FFFFh. It does so only while a software-controlled overlay enable bit is set.

The core presents a request for one cycle, with the read/write flag, the address and the write data. The block captures it at the end of that first cycle. In the second cycle it either drives the external bus or works on the internal array. At the end of the second cycle it delivers read data or commits the write. A single-bit configuration write port sets or clears the overlay enable, and the current value is visible on an output.

The RAM contents have no reset. A write that is already in its second cycle when reset arrives still completes. A write whose first cycle sees reset is dropped.

Top module: `xram_map_ctrl`

## Requirements
- R1: The overlay enable output `map_en_o` reads 0 after reset. A configuration write (`cfg_we_i`=1, `cfg_wdata_i`=1 enables, 0 disables) shows on `map_en_o` one clock edge later.
- R2: With the overlay disabled, every access goes to the external bus, including those in FF00h–FFFFh. In the second cycle `ext_rd_o` or `ext_wr_o` is high and `ext_addr_o` carries the request address.
- R3: With the overlay enabled, an access to 0000h–FEFFh goes to the external bus in the same way as in R2.
- R4: With the overlay enabled, an access to FF00h–FFFFh uses the on-chip RAM, indexed by address bits [7:0]. No external strobe is raised, and `ext_addr_o` stays 0 during the access.
- R5: A read raises `rvalid_o` for exactly one cycle after the clock edge that ends its second cycle. For an external read, `rdata_o` holds the `ext_rdata_i` value sampled at that edge.
- R6: An internal write commits at the edge that ends its second cycle. A later internal read of that address returns the written byte, and the value on `ext_rdata_i` does not affect the result.
- R7: A write that sees reset at the edge ending its first cycle leaves the RAM location unchanged.
- R8: A write whose second cycle is interrupted by reset still commits its new value.
- R9: Reset does not clear or change the RAM contents.
- R10: A change of the overlay enable affects only the accesses that start after it. The route of an access is fixed by the enable value present in its first cycle. A write to the enable bit in that same cycle or in the second cycle does not change it.
- R11: A request presented while an access is in its second cycle is ignored. It raises no `rvalid_o` and does not replace the data of the access in progress.
- R12: An external write drives `ext_wr_o` high for its second cycle, with `ext_wdata_o` equal to the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, first cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| cfg_we_i | input | 1 | Overlay enable write strobe |
| cfg_wdata_i | input | 1 | New overlay enable value |
| ext_rdata_i | input | 8 | Read data from the external bus |
| map_en_o | output | 1 | Current overlay enable |
| rdata_o | output | 8 | Read data |
| rvalid_o | output | 1 | Read data valid pulse |
| ext_addr_o | output | 16 | External bus address |
| ext_wdata_o | output | 8 | External bus write data |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data and an 8-bit RAM index, so the overlay window is exactly FF00h–FFFFh. These values put both edges of the window within reach: FEFFh just below it, and FF00h and FFFFh at its ends. The full 64 KB space is also covered down to 0000h. With a one-byte data path, the read-back values show whether a byte came from the array or from the external bus.

// File: rtl/xmap_pkg.sv
package xmap_pkg;

  typedef enum logic {
    ROUTE_EXT = 1'b0,
    ROUTE_INT = 1'b1
  } route_e;

  typedef struct packed {
    logic   we;
    route_e route;
  } acc_ctl_t;

endpackage

// File: rtl/xmap_decode.sv
module xmap_decode
  import xmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_en_i,
  output route_e            route_o
);

  localparam int TAG_W = ADDR_W - RAM_AW;

  logic hit;

  generate
    if (TAG_W == 0) begin : g_full
      assign hit = 1'b1;
    end else begin : g_top
      // window is the top 2**RAM_AW bytes of the space
      assign hit = &addr_i[ADDR_W-1:RAM_AW];
    end
  endgenerate

  assign route_o = (map_en_i && hit) ? ROUTE_INT : ROUTE_EXT;

endmodule

// File: rtl/xmap_ram.sv
module xmap_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // R6
  ram_commit_chk: assert property (@(posedge clk_i)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/xram_map_ctrl.sv
module xram_map_ctrl
  import xmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wdata_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              map_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o
);

  logic              map_en_q;
  logic              acc_q;
  acc_ctl_t          ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_go_q;
  logic              accept;
  logic              ext_act;
  route_e            route_d;
  logic [DATA_W-1:0] ram_rdata;

  assign map_en_o = map_en_q;
  assign accept   = req_i & ~acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       map_en_q <= 1'b0;
    else if (cfg_we_i) map_en_q <= cfg_wdata_i;
  end

  xmap_decode #(
    .ADDR_W (ADDR_W),
    .RAM_AW (RAM_AW)
  ) i_decode (
    .addr_i   (addr_i),
    .map_en_i (map_en_q),
    .route_o  (route_d)
  );

  // access phase: acc_q marks the second cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      ctl_q <= '{we: 1'b0, route: ROUTE_EXT};
    end else begin
      acc_q <= accept;
      if (accept) ctl_q <= '{we: we_i, route: route_d};
    end
  end

  // commit stage is reset-free so a write already past its first cycle survives reset
  always_ff @(posedge clk_i) begin
    if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
    wr_go_q <= accept & rst_ni & we_i & (route_d == ROUTE_INT);
  end

  xmap_ram #(
    .DATA_W (DATA_W),
    .AW     (RAM_AW)
  ) i_ram (
    .clk_i   (clk_i),
    .we_i    (wr_go_q),
    .waddr_i (addr_q[RAM_AW-1:0]),
    .wdata_i (wdata_q),
    .raddr_i (addr_q[RAM_AW-1:0]),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= acc_q & ~ctl_q.we;
      if (acc_q && !ctl_q.we)
        rdata_o <= (ctl_q.route == ROUTE_INT) ? ram_rdata : ext_rdata_i;
    end
  end

  assign ext_act     = acc_q & (ctl_q.route == ROUTE_EXT);
  assign ext_rd_o    = ext_act & ~ctl_q.we;
  assign ext_wr_o    = ext_act & ctl_q.we;
  assign ext_addr_o  = ext_act ? addr_q : '0;
  assign ext_wdata_o = ext_wr_o ? wdata_q : '0;

  // R1
  map_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> map_en_o == $past(cfg_wdata_i));

  // R2
  ext_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !map_en_o) |=> ((ext_rd_o || ext_wr_o) && ext_addr_o == $past(addr_i)));

  // R4
  int_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && route_d == ROUTE_INT) |=> (!ext_rd_o && !ext_wr_o && ext_addr_o == '0));

  // R5
  read_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !we_i) |=> ##1 rvalid_o);

endmodule

// File: tb/test_xram_map_ctrl.sv
`timescale 1ns/1ps
module test_xram_map_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_wdata_i = 1'b0;
  logic [7:0]  ext_rdata_i = '0;
  logic        map_en_o;
  logic [7:0]  rdata_o;
  logic        rvalid_o;
  logic [15:0] ext_addr_o;
  logic [7:0]  ext_wdata_o;
  logic        ext_rd_o;
  logic        ext_wr_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xram_map_ctrl i_xram_map_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .ext_rdata_i (ext_rdata_i),
    .map_en_o    (map_en_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o),
    .ext_rd_o    (ext_rd_o),
    .ext_wr_o    (ext_wr_o)
  );

  typedef struct packed {
    logic        en;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  xdat;
    logic        ext;
    logic [7:0]  exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 16'hFF20, 8'hA5, 8'h00, 1'b1, 8'h00},
    '{1'b1, 1'b1, 16'hFF20, 8'h3C, 8'h00, 1'b0, 8'h00},
    '{1'b0, 1'b0, 16'hFF20, 8'h00, 8'h77, 1'b1, 8'h77},
    '{1'b1, 1'b0, 16'hFF20, 8'h00, 8'hEE, 1'b0, 8'h3C},
    '{1'b1, 1'b0, 16'hFEFF, 8'h00, 8'h5A, 1'b1, 8'h5A},
    '{1'b1, 1'b1, 16'hFEFF, 8'h99, 8'h00, 1'b1, 8'h00},
    '{1'b1, 1'b1, 16'hFFFF, 8'hC3, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b0, 16'hFFFF, 8'h00, 8'hEE, 1'b0, 8'hC3},
    '{1'b1, 1'b1, 16'hFF00, 8'h81, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b0, 16'hFF00, 8'h00, 8'hEE, 1'b0, 8'h81},
    '{1'b1, 1'b0, 16'h0000, 8'h00, 8'h12, 1'b1, 8'h12},
    '{1'b0, 1'b0, 16'hFFFF, 8'h00, 8'hE4, 1'b1, 8'hE4}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic set_map(input logic en);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_wdata_i = en;
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk("R1", map_en_o, en);
  endtask

  task automatic access(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                        input logic [7:0] xd, input logic ext, input logic [7:0] exp,
                        input string rq_bus, input string rq_dat);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wd; ext_rdata_i = xd;
    @(negedge clk);
    req_i = 1'b0;
    chk(rq_bus, ext_rd_o, ext && !we);
    chk(rq_bus, ext_wr_o, ext && we);
    chk(rq_bus, ext_addr_o, ext ? addr : 16'h0);
    if (ext && we) chk("R12", ext_wdata_o, wd);
    @(negedge clk);
    chk("R5", rvalid_o, !we);
    if (!we) chk(rq_dat, rdata_o, exp);
  endtask

  function automatic string bus_tag(input vec_t v);
    if (!v.en) return "R2";
    if (v.ext) return v.we ? "R12" : "R3";
    return "R4";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", map_en_o, 0);
    chk("R5", rvalid_o, 0);
    chk("R2", ext_rd_o | ext_wr_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (map_en_o !== VEC[i].en) set_map(VEC[i].en);
      access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].xdat, VEC[i].ext, VEC[i].exp,
             bus_tag(VEC[i]), VEC[i].ext ? "R5" : "R6");
    end

    // R10: enable set in the request cycle keeps the old route
    set_map(1'b1);
    access(1'b1, 16'hFF40, 8'h66, 8'h00, 1'b0, 8'h00, "R4", "R6");
    set_map(1'b0);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'hFF40; ext_rdata_i = 8'h3B;
    cfg_we_i = 1'b1; cfg_wdata_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; cfg_we_i = 1'b0;
    chk("R10", ext_rd_o, 1);
    chk("R1", map_en_o, 1);
    @(negedge clk);
    chk("R10", rdata_o, 8'h3B);
    // R10: enable cleared in the second cycle keeps the internal route
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'hFF40; ext_rdata_i = 8'h3B;
    @(negedge clk);
    req_i = 1'b0; cfg_we_i = 1'b1; cfg_wdata_i = 1'b0;
    chk("R10", ext_rd_o, 0);
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk("R10", rdata_o, 8'h66);
    chk("R1", map_en_o, 0);
    access(1'b0, 16'hFF40, 8'h00, 8'h4D, 1'b1, 8'h4D, "R10", "R10");

    // R11: request during the second cycle is ignored
    set_map(1'b1);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'hFF20; ext_rdata_i = 8'hEE;
    @(negedge clk);
    addr_i = 16'hFF00;
    @(negedge clk);
    req_i = 1'b0;
    chk("R11", rvalid_o, 1);
    chk("R11", rdata_o, 8'h3C);
    @(negedge clk);
    chk("R11", rvalid_o, 0);
    chk("R11", rdata_o, 8'h3C);

    // R7: reset seen in the first cycle drops the write
    access(1'b1, 16'hFF10, 8'h11, 8'h00, 1'b0, 8'h00, "R4", "R6");
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'hFF10; wdata_i = 8'h22; rst_ni = 1'b0;
    @(negedge clk);
    req_i = 1'b0;
    chk("R1", map_en_o, 0);
    chk("R7", ext_wr_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    set_map(1'b1);
    access(1'b0, 16'hFF10, 8'h00, 8'hEE, 1'b0, 8'h11, "R4", "R7");

    // R8: reset in the second cycle still commits
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'hFF10; wdata_i = 8'h22;
    @(negedge clk);
    req_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    set_map(1'b1);
    access(1'b0, 16'hFF10, 8'h00, 8'hEE, 1'b0, 8'h22, "R4", "R8");
    // R9: contents untouched by the resets
    access(1'b0, 16'hFF20, 8'h00, 8'hEE, 1'b0, 8'h3C, "R4", "R9");
    access(1'b0, 16'hFFFF, 8'h00, 8'hEE, 1'b0, 8'hC3, "R4", "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule